// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

The arbiter looks at a set of interrupt sources, each with a pending flag and a priority number, and names the single most favoured pending one. A smaller priority number is more favoured. The choice is made in two encoder stages instead of a chain of pairwise comparators. First, one bit is set per priority level that has anything pending, and the lowest set bit gives the winning level. Second, one bit is set per source that is pending at exactly that level, and the lowest set bit gives the winning source.

The winning index and its priority are registered together with a valid flag. The flag is raised only when the winner is strictly more favoured than a current-priority threshold input, so the processor is only told about interrupts it would accept. Source `s` drives its priority on bits `[s*PRIO_W +: PRIO_W]` of the packed priority bus.

Top module: `irq_favour_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `out_valid`=0, `out_src`=0 and `out_prio`=all ones.
- R2: When at least one source is pending, `out_prio` holds the numerically smallest priority found among the pending sources.
- R3: When several pending sources share the winning priority, `out_src` holds the lowest-numbered of them.
- R4: A source whose pending flag is 0 has no effect on the outputs, whatever its priority.
- R5: `out_valid` is 1 only when something is pending and the winning priority is strictly less than `cur_prio`. With equal or larger values, `out_valid` is 0 and `out_src`/`out_prio` still report the winner.
- R6: When no source is pending, `out_prio` reads all ones, `out_src` reads 0 and `out_valid` is 0.
- R7: Outputs change only at a clock edge and reflect the inputs sampled at that edge, which gives one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pending | input | N_SRC | One pending flag per source |
| src_prio | input | N_SRC*PRIO_W | Packed priorities, source s at [s*PRIO_W +: PRIO_W] |
| cur_prio | input | PRIO_W | Current processor priority threshold |
| out_valid | output | 1 | Winner is pending and more favoured than cur_prio |
| out_src | output | $clog2(N_SRC) | Index of the winning source |
| out_prio | output | PRIO_W | Priority of the winner, all ones when idle |

## Verification
Every result is due at the first rising edge after the inputs are driven, because only one register stage sits between the inputs and the outputs. The bench drives inputs on the falling edge and checks all three outputs 1 ns after the next rising edge. For the latency check it also samples just before that edge, to show that the previous result is still held. Reset is checked in the same way, one edge after `rst` is raised while sources are pending.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // True when bit k of the binary number pos is set.
  function automatic bit pos_has_bit(input int pos, input int k);
    return ((pos >> k) & 1) == 1;
  endfunction
endpackage

// File: rtl/pend_level_map.sv
module pend_level_map #(
  parameter int N_SRC  = 16,
  parameter int PRIO_W = 8
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  output logic [(1<<PRIO_W)-1:0]  lvl_vec
);
  localparam int LV = 1 << PRIO_W;

  // Each pending source sets the bit that stands for its priority level.
  always_comb begin
    lvl_vec = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (pend[s]) lvl_vec = lvl_vec | (LV'(1) << prio[s*PRIO_W +: PRIO_W]);
    end
  end
endmodule

// File: rtl/lsb_index_enc.sv
module lsb_index_enc #(
  parameter int W  = 256,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  import irq_arb_pkg::*;

  logic [W-1:0] iso;

  // Trailing-zero style: keep only the lowest set bit, then build each
  // index bit as an OR over the positions whose number has that bit set.
  always_comb begin
    iso   = vec & (~vec + W'(1));
    found = |vec;
    idx   = '0;
    for (int k = 0; k < IW; k++) begin
      for (int p = 0; p < W; p++) begin
        if (pos_has_bit(p, k)) idx[k] = idx[k] | iso[p];
      end
    end
  end
endmodule

// File: rtl/src_level_match.sv
module src_level_match #(
  parameter int N_SRC  = 16,
  parameter int PRIO_W = 8
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]       lvl,
  output logic [N_SRC-1:0]        hit
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_cmp
    assign hit[s] = pend[s] && (prio[s*PRIO_W +: PRIO_W] == lvl);
  end
endmodule

// File: rtl/irq_favour_arbiter.sv
module irq_favour_arbiter #(
  parameter int N_SRC  = 16,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        src_pending,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]       cur_prio,
  output logic                    out_valid,
  output logic [SRC_W-1:0]        out_src,
  output logic [PRIO_W-1:0]       out_prio
);
  localparam int LV = 1 << PRIO_W;

  logic [LV-1:0]     lvl_vec;
  logic [PRIO_W-1:0] lvl_idx;
  logic              lvl_any;
  logic [N_SRC-1:0]  src_hit;
  logic [SRC_W-1:0]  src_idx;
  logic              src_any;

  // Stage 1: per-level pending vector and its encoder.
  pend_level_map #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_lvl_map (
    .pend(src_pending), .prio(src_prio), .lvl_vec(lvl_vec)
  );

  lsb_index_enc #(.W(LV), .IW(PRIO_W)) u_lvl_enc (
    .vec(lvl_vec), .idx(lvl_idx), .found(lvl_any)
  );

  // Stage 2: sources pending at the chosen level, lowest index wins.
  src_level_match #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_src_match (
    .pend(src_pending), .prio(src_prio), .lvl(lvl_idx), .hit(src_hit)
  );

  lsb_index_enc #(.W(N_SRC), .IW(SRC_W)) u_src_enc (
    .vec(src_hit), .idx(src_idx), .found(src_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_src   <= '0;
      out_prio  <= '1;
    end else if (lvl_any) begin
      out_valid <= (lvl_idx < cur_prio);
      out_src   <= src_idx;
      out_prio  <= lvl_idx;
    end else begin
      out_valid <= 1'b0;
      out_src   <= '0;
      out_prio  <= '1;
    end
  end

  // Masks of level bits below the chosen level; none may be set.
  logic [LV-1:0] below_mask;
  assign below_mask = (LV'(1) << lvl_idx) - LV'(1);

  assert_lvl_present_R2: assert property (@(posedge clk) disable iff (rst)
    lvl_any |-> lvl_vec[lvl_idx]);

  assert_lvl_lowest_R2: assert property (@(posedge clk) disable iff (rst)
    lvl_any |-> ((lvl_vec & below_mask) == '0));

  assert_src_found_R3: assert property (@(posedge clk) disable iff (rst)
    lvl_any |-> src_any);

  assert_src_pending_R4: assert property (@(posedge clk) disable iff (rst)
    src_any |-> (src_pending[src_idx] &&
                 src_prio[src_idx*PRIO_W +: PRIO_W] == lvl_idx));

  assert_valid_threshold_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_prio < $past(cur_prio)));

  assert_idle_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    !(|src_pending) |=> (!out_valid && out_prio == '1 && out_src == '0));
endmodule

// File: tb/irq_favour_arbiter_test.sv
module irq_favour_arbiter_test;
  localparam int N  = 16;
  localparam int PW = 8;
  localparam int SW = 4;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_pending = '0;
  logic [N*PW-1:0] src_prio = '0;
  logic [PW-1:0] cur_prio = '1;
  logic          out_valid;
  logic [SW-1:0] out_src;
  logic [PW-1:0] out_prio;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  irq_favour_arbiter #(.N_SRC(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .src_pending(src_pending), .src_prio(src_prio),
    .cur_prio(cur_prio), .out_valid(out_valid), .out_src(out_src),
    .out_prio(out_prio)
  );

  // Entry: pend, srcA, prioA, srcB, prioB, cur, exp_valid, exp_src, exp_prio.
  // Sources other than A and B carry priority 8'hC0.
  localparam logic [60:0] TBL [NV] = '{
    {16'h0001, 4'd0, 8'd10, 4'd1, 8'd20, 8'hFF, 1'b1, 4'd0, 8'd10},   // R2
    {16'h0003, 4'd0, 8'd10, 4'd1, 8'd20, 8'hFF, 1'b1, 4'd0, 8'd10},   // R2
    {16'h0002, 4'd0, 8'd10, 4'd1, 8'd20, 8'hFF, 1'b1, 4'd1, 8'd20},   // R4
    {16'h8001, 4'd15, 8'd3, 4'd0, 8'd9,  8'hFF, 1'b1, 4'd15, 8'd3},   // R2
    {16'h0030, 4'd4, 8'd7,  4'd5, 8'd7,  8'hFF, 1'b1, 4'd4, 8'd7},    // R3
    {16'h0030, 4'd5, 8'd7,  4'd4, 8'd7,  8'hFF, 1'b1, 4'd4, 8'd7},    // R3
    {16'h0001, 4'd0, 8'd10, 4'd1, 8'd20, 8'd10, 1'b0, 4'd0, 8'd10},   // R5
    {16'h0001, 4'd0, 8'd10, 4'd1, 8'd20, 8'd11, 1'b1, 4'd0, 8'd10},   // R5
    {16'h0001, 4'd0, 8'd0,  4'd1, 8'd20, 8'd0,  1'b0, 4'd0, 8'd0},    // R5
    {16'hFFFF, 4'd9, 8'h40, 4'd12, 8'h40, 8'hFF, 1'b1, 4'd9, 8'h40},  // R3
    {16'hFFFF, 4'd3, 8'hFF, 4'd7, 8'hFF, 8'hFF, 1'b1, 4'd0, 8'hC0},   // R2
    {16'h0080, 4'd7, 8'hFF, 4'd3, 8'hFF, 8'hFF, 1'b0, 4'd7, 8'hFF},   // R5
    {16'h0000, 4'd2, 8'd1,  4'd6, 8'd0,  8'hFF, 1'b0, 4'd0, 8'hFF},   // R6
    {16'h0400, 4'd10, 8'd0, 4'd11, 8'd0, 8'd1,  1'b1, 4'd10, 8'd0}    // R4
  };

  task automatic check(input string req, input logic v, input logic [SW-1:0] s,
                       input logic [PW-1:0] p);
    n_checks++;
    if (out_valid !== v || out_src !== s || out_prio !== p) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b src=%0d prio=%0h, expected valid=%0b src=%0d prio=%0h",
               req, out_valid, out_src, out_prio, v, s, p);
    end
  endtask

  task automatic drive(input logic [60:0] e);
    src_pending = e[60:45];
    for (int s = 0; s < N; s++) src_prio[s*PW +: PW] = 8'hC0;
    src_prio[e[44:41]*PW +: PW] = e[40:33];
    src_prio[e[32:29]*PW +: PW] = e[28:21];
    cur_prio = e[20:13];
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 1'b0, 4'd0, 8'hFF);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(posedge clk);
      #1;
      check($sformatf("R7 vector %0d", i), TBL[i][12], TBL[i][11:8], TBL[i][7:0]);
      @(negedge clk);
    end

    // R7: new inputs must not show before the next edge.
    drive({16'h0100, 4'd8, 8'd5, 4'd9, 8'd6, 8'hFF, 1'b1, 4'd8, 8'd5});
    #3;
    check("R7 held before edge", 1'b1, 4'd10, 8'd0);
    @(posedge clk);
    #1;
    check("R7 after edge", 1'b1, 4'd8, 8'd5);

    // R4: a very favoured non-pending source stays invisible.
    @(negedge clk);
    drive({16'h0100, 4'd8, 8'd5, 4'd2, 8'd0, 8'hFF, 1'b0, 4'd0, 8'd0});
    @(posedge clk);
    #1;
    check("R4 idle favoured source", 1'b1, 4'd8, 8'd5);

    // R1: reset while sources are pending.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset while pending", 1'b0, 4'd0, 8'hFF);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 release", 1'b1, 4'd8, 8'd5);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule